// File: doc/BRIEF.md
# Relocatable On-Chip RAM Address Router

This block sorts each incoming transaction address into one of three outcomes: it hits the on-chip RAM, it is sent on to external DRAM, or it hits nothing and goes to the default target with a miss flag. The RAM holds 256 KB in four 64 KB sections. A 4-bit configuration word chooses, section by section, whether that section appears at the bottom of the 32-bit map (0x0000_0000 to 0x0003_FFFF) or at the top (0xFFFC_0000 to 0xFFFF_FFFF).

Requests arrive from two kinds of master, chosen by `req_cpu`. Processor-side requests first pass an address filter. The filter is a window in 1 MB steps, and its start and end are compared against address bits [31:20]. While the filter is enabled, it sends any processor-side address inside the window to DRAM. When the filter does not take a processor-side request, a section that is mapped high can also be reached at 0x000C_0000 to 0x000F_FFFF. Switch-side requests skip both the filter and this alias window.

Every decision is registered, so it appears one cycle after the request, qualified by `rsp_valid`. The filter enable is a register that any reset turns on.

Top module: `ocm_addr_router`

## Requirements
- R1: While reset is held and on the first cycle after it, `rsp_valid` is 0, `rsp_tgt` is 2'b10, `rsp_miss` is 0 and `rsp_off` is 0. The filter enable is 1.
- R2: An address 0x0000_0000 to 0x0003_FFFF whose section bits [17:16] name a low-mapped section (`sec_hi` bit clear) gives `rsp_tgt` = 2'b00 (RAM) and `rsp_off` = {addr[17:16], addr[15:0]}. This holds unless the filter takes the request.
- R3: An address 0xFFFC_0000 to 0xFFFF_FFFF whose section bits [17:16] name a high-mapped section (`sec_hi` bit set) gives `rsp_tgt` = 2'b00 and `rsp_off` = {addr[17:16], addr[15:0]}.
- R4: An address in one range whose section is mapped to the other range does not hit the RAM.
- R5: A processor-side request (`req_cpu` = 1) is sent to DRAM when the filter is enabled and addr[31:20] lies between `flt_start` and `flt_end` inclusive. This takes priority over any section hit. The result is `rsp_tgt` = 2'b01, `rsp_miss` = 0 and `rsp_off` = 0.
- R6: A switch-side request (`req_cpu` = 0) is never sent to DRAM, whatever the filter settings.
- R7: A processor-side request at 0x000C_0000 to 0x000F_FFFF that the filter does not take, and whose section bits [17:16] name a high-mapped section, hits the RAM with `rsp_off` = {addr[17:16], addr[15:0]}.
- R8: The alias window of R7 gives no RAM hit to switch-side requests. It also gives no RAM hit for low-mapped sections.
- R9: A request that is neither a RAM hit nor sent to DRAM gives `rsp_tgt` = 2'b10, `rsp_miss` = 1 and `rsp_off` = 0.
- R10: `rsp_valid` equals `req_valid` of the previous cycle. Each result belongs to the request of the previous cycle.
- R11: A cycle with `flt_we` = 1 loads `flt_en_d` into the filter enable. While the enable is 0, processor-side requests decode exactly as in R2, R3 and R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request address |
| req_cpu | input | 1 | 1 = processor-side master, 0 = switch-side master |
| sec_hi | input | 4 | Bit n set maps section n high, clear maps it low |
| flt_start | input | 12 | First 1 MB block of the filter window |
| flt_end | input | 12 | Last 1 MB block of the filter window |
| flt_we | input | 1 | Load strobe for the filter enable |
| flt_en_d | input | 1 | Value loaded into the filter enable |
| rsp_valid | output | 1 | Result valid |
| rsp_tgt | output | 2 | 00 RAM, 01 DRAM, 10 default target |
| rsp_off | output | 18 | RAM offset: section index then 16-bit offset |
| rsp_miss | output | 1 | Decode miss |

## Verification
The alias window is the hardest case to reach. It only opens for processor-side requests that the filter does not take, and the filter comes out of reset enabled and covering the first megabyte. The stimulus gets there in two ways. First, it clears the enable through the load strobe and then probes 0x000C_0000 to 0x000F_FFFF with both high-mapped and low-mapped sections. Second, it re-enables the filter with a window moved above the first megabyte and probes the alias again. A later reset shows that the enable comes back on.

// File: rtl/ocm_addr_router.sv
module ocm_addr_router #(
  parameter int ADDR_W = 32,
  parameter int SEC_W  = 16,
  parameter int NSEC   = 4,
  parameter int FLT_LSB = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  req_cpu,
  input  logic [NSEC-1:0]       sec_hi,
  input  logic [ADDR_W-FLT_LSB-1:0] flt_start,
  input  logic [ADDR_W-FLT_LSB-1:0] flt_end,
  input  logic                  flt_we,
  input  logic                  flt_en_d,
  output logic                  rsp_valid,
  output logic [1:0]            rsp_tgt,
  output logic [SEC_W+$clog2(NSEC)-1:0] rsp_off,
  output logic                  rsp_miss
);
  localparam int SEL_W = $clog2(NSEC);
  localparam int OFF_W = SEC_W + SEL_W;
  localparam int TOP_W = ADDR_W - OFF_W;
  localparam int FLT_W = ADDR_W - FLT_LSB;
  localparam int WIN_W = FLT_LSB - OFF_W;
  localparam logic [1:0] TGT_RAM = 2'b00;
  localparam logic [1:0] TGT_DRAM = 2'b01;
  localparam logic [1:0] TGT_DEF = 2'b10;

  logic flt_en;
  logic [SEL_W-1:0] sel;
  logic [TOP_W-1:0] top;
  logic [FLT_W-1:0] mb;
  logic flt_hit, lo_hit, hi_hit, al_hit, ram_hit;
  logic [1:0] tgt_n;

  assign sel = req_addr[OFF_W-1:SEC_W];
  assign top = req_addr[ADDR_W-1:OFF_W];
  assign mb  = req_addr[ADDR_W-1:FLT_LSB];

  assign flt_hit = req_cpu && flt_en && (mb >= flt_start) && (mb <= flt_end);
  assign lo_hit  = (top == '0) && !sec_hi[sel];
  assign hi_hit  = (top == '1) && sec_hi[sel];
  assign al_hit  = req_cpu && (mb == '0) && (req_addr[FLT_LSB-1:OFF_W] == {WIN_W{1'b1}}) && sec_hi[sel];
  assign ram_hit = !flt_hit && (lo_hit || hi_hit || al_hit);
  assign tgt_n   = flt_hit ? TGT_DRAM : (ram_hit ? TGT_RAM : TGT_DEF);

  always_ff @(posedge clk) begin
    if (!rst_n) flt_en <= 1'b1;
    else if (flt_we) flt_en <= flt_en_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_tgt   <= TGT_DEF;
      rsp_off   <= '0;
      rsp_miss  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_tgt  <= tgt_n;
        rsp_off  <= ram_hit ? {sel, req_addr[SEC_W-1:0]} : '0;
        rsp_miss <= (tgt_n == TGT_DEF);
      end
    end
  end
endmodule

module ocm_addr_router_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_cpu,
  input logic              rsp_valid,
  input logic [1:0]        rsp_tgt,
  input logic [OFF_W-1:0]  rsp_off,
  input logic              rsp_miss
);
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_miss_default_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_tgt == 2'b10 && rsp_off == '0));
  assert_dram_only_cpu_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_cpu) |=> (rsp_tgt != 2'b01));
  assert_ram_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_cpu && req_addr[31:18] == '0) |=>
      (rsp_tgt == 2'b00 ? rsp_off[15:0] == $past(req_addr[15:0]) : rsp_miss));
  assert_dram_no_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_tgt == 2'b01) |-> (!rsp_miss && rsp_off == '0));
endmodule

bind ocm_addr_router ocm_addr_router_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_cpu(req_cpu), .rsp_valid(rsp_valid), .rsp_tgt(rsp_tgt),
  .rsp_off(rsp_off), .rsp_miss(rsp_miss)
);

// File: tb/ocm_addr_router_bench.sv
module ocm_addr_router_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [31:0] req_addr = '0;
  logic req_cpu = 0;
  logic [3:0] sec_hi = 4'b0101;
  logic [11:0] flt_start = '0, flt_end = '0;
  logic flt_we = 0, flt_en_d = 0;
  logic rsp_valid, rsp_miss;
  logic [1:0] rsp_tgt;
  logic [17:0] rsp_off;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  ocm_addr_router u_ocm_addr_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_cpu(req_cpu), .sec_hi(sec_hi), .flt_start(flt_start), .flt_end(flt_end),
    .flt_we(flt_we), .flt_en_d(flt_en_d), .rsp_valid(rsp_valid),
    .rsp_tgt(rsp_tgt), .rsp_off(rsp_off), .rsp_miss(rsp_miss)
  );

  task automatic chk(input string req, input logic [22:0] act, input logic [22:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic probe(input string req, input logic cpu, input logic [31:0] a,
                       input logic [1:0] tgt, input logic [17:0] off, input logic miss);
    @(negedge clk);
    req_valid = 1; req_cpu = cpu; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(req, {rsp_valid, rsp_tgt, rsp_off, rsp_miss}, {1'b1, tgt, off, miss});
  endtask

  task automatic set_filter(input logic en);
    @(negedge clk);
    flt_we = 1; flt_en_d = en;
    @(negedge clk);
    flt_we = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R1 held", {rsp_valid, rsp_tgt, rsp_off, rsp_miss}, {1'b0, 2'b10, 18'h0, 1'b0});
    rst_n = 1;
    @(negedge clk);
    chk("R1 after", {rsp_valid, rsp_tgt, rsp_off, rsp_miss}, {1'b0, 2'b10, 18'h0, 1'b0});
  endtask

  task automatic t_plain_map;
    probe("R2 low sec1", 0, 32'h0001_1234, 2'b00, 18'h11234, 0);
    probe("R2 low sec3", 0, 32'h0003_FFFF, 2'b00, 18'h3FFFF, 0);
    probe("R3 high sec2", 0, 32'hFFFE_ABCD, 2'b00, 18'h2ABCD, 0);
    probe("R3 high sec0", 0, 32'hFFFC_0007, 2'b00, 18'h00007, 0);
    probe("R4 sec0 at low", 0, 32'h0000_0010, 2'b10, 18'h0, 1);
    probe("R4 sec1 at high", 0, 32'hFFFD_0000, 2'b10, 18'h0, 1);
    probe("R8 switch alias", 0, 32'h000E_0042, 2'b10, 18'h0, 1);
    probe("R9 unmapped", 0, 32'h4000_0000, 2'b10, 18'h0, 1);
  endtask

  task automatic t_filter_on;
    probe("R5 cpu low", 1, 32'h0001_1234, 2'b01, 18'h0, 0);
    probe("R5 cpu alias filtered", 1, 32'h000E_0042, 2'b01, 18'h0, 0);
    probe("R3 cpu high", 1, 32'hFFFE_0001, 2'b00, 18'h20001, 0);
  endtask

  task automatic t_filter_off;
    set_filter(0);
    probe("R11 cpu low unfiltered", 1, 32'h0001_1234, 2'b00, 18'h11234, 0);
    probe("R7 alias sec2", 1, 32'h000E_0042, 2'b00, 18'h20042, 0);
    probe("R8 alias low sec1", 1, 32'h000D_0000, 2'b10, 18'h0, 1);
  endtask

  task automatic t_filter_moved;
    flt_start = 12'h001; flt_end = 12'h002;
    set_filter(1);
    probe("R5 window", 1, 32'h0015_0000, 2'b01, 18'h0, 0);
    probe("R6 switch window", 0, 32'h0015_0000, 2'b10, 18'h0, 1);
    probe("R9 cpu past window", 1, 32'h0030_0000, 2'b10, 18'h0, 1);
    probe("R7 alias sec0", 1, 32'h000C_0000, 2'b00, 18'h00000, 0);
    flt_start = 12'h000; flt_end = 12'h000;
  endtask

  task automatic t_latency;
    @(negedge clk);
    req_valid = 1; req_cpu = 0; req_addr = 32'h0001_0000;
    @(negedge clk);
    req_valid = 0;
    chk("R10 valid", {22'h0, rsp_valid}, 23'h1);
    @(negedge clk);
    chk("R10 idle", {22'h0, rsp_valid}, 23'h0);
  endtask

  task automatic t_reset_reenables;
    set_filter(0);
    t_reset;
    probe("R1 filter on after reset", 1, 32'h0001_1234, 2'b01, 18'h0, 0);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_plain_map;
        t_filter_on;
        t_filter_off;
        t_filter_moved;
        t_latency;
        t_reset_reenables;
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule